// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Pin Interrupts

This block is a general-purpose I/O controller that sits on an APB slave. It serves up to four ports of up to 32 pins each. Every port has an output-value register and a drive-enable register that go straight to the pad cells, plus a read-only view of the pad inputs after a two-flop synchronizer.

The first port (port 0) also detects interrupts. Each of its pins has its own settings:
- level or edge detection, with a polarity choice;
- an enable bit and a mask bit;
- an optional input debounce, which accepts a new pin value only after a set number of samples taken on a debounce tick.

Edge events stay latched until software clears them by writing ones to a clear register. All visible pin interrupts are ORed onto one interrupt line.

Software programs the registers with ordinary APB writes and reads. Reads return zero-padded 32-bit words. Reads and writes to offsets that decode to no register have no effect.

Top module: `gpio_apb_ctrl`

## Requirements
- R1: After reset, every register reads 0, `pad_out` and `pad_oe` are all 0, and `irq` is low.
- R2: Port p has an output-value register at offset 12*p and a drive-enable register at 12*p+4. A written value appears on `pad_out` and `pad_oe` (1 = drive) for that port's pins after the APB write edge, and reads back unchanged.
- R3: The input view of port p reads at offset 0x50+4*p. Reads of ports 1 to 3 return `ext_in` as it was two `pclk` edges earlier.
- R4: On port 0, a pin with type bit 0 (offset 0x38) is level-sensitive. It is pending while its synchronized input equals its polarity bit (offset 0x3C; 1 = high, 0 = low). It drops with no clear once the input leaves that level.
- R5: A port 0 pin with type bit 1 is edge-sensitive: polarity 1 selects rising edges and polarity 0 selects falling edges. The event is latched and stays latched until a 1 is written to that pin's bit of the clear register (offset 0x4C). Zero bits in that write leave the pin's latch unchanged. An event becomes visible on the third `pclk` edge after the input changes.
- R6: If a new edge arrives in the same cycle as the clear write for its pin, the latch stays set.
- R7: A mask bit (offset 0x34) of 1 hides the pin from status and `irq` but keeps its edge latch. An all-ones mask forces `irq` low. An edge latch sets only while the pin's enable bit (offset 0x30) is 1 and the pin is edge-sensitive.
- R8: The status word (offset 0x40) reads as pending AND enable AND NOT mask. `irq` is high exactly when any status bit is 1.
- R9: With the pin's debounce bit set (offset 0x48), a changed port 0 input is accepted only after DB_CYCLES consecutive `db_tick` samples that all show the new value. A shorter glitch never reaches the input view or the interrupt logic. Without ticks, the accepted value does not change.
- R10: Ports 1 to 3 have no interrupt logic. Their input changes never affect `irq`. Writes to offsets that decode to no register are ignored, and such offsets read 0.
- R11: Bits at and above PORT_WIDTH read 0 and cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and logic clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, zero when not reading |
| ext_in | input | NUM_PORTS*PORT_WIDTH | Pad input values, port 0 in the low bits |
| pad_out | output | NUM_PORTS*PORT_WIDTH | Pad output values |
| pad_oe | output | NUM_PORTS*PORT_WIDTH | Pad drive enables, 1 = drive |
| db_tick | input | 1 | Debounce sample strobe, one `pclk` cycle wide |
| irq | output | 1 | Combined pin interrupt |

## Verification
A wrong edge latch shows on `irq` and in the status word one cycle after the input reaches the detector. It does not go away until the clear-register write, so a lost or stuck latch stays visible for as long as the bench watches. A broken synchronizer or debounce counter shifts the cycle in which the input view changes. The bench measures these latencies at exact edges, so an extra or missing flop is caught within two or three cycles of a pin change. A mis-decoded offset shows up on the next readback or on `pad_out`/`pad_oe` right after the write edge.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

  localparam int unsigned MAX_PORTS = 4;

  // Interrupt block of port 0 and the input views
  localparam logic [7:0] OFS_IEN   = 8'h30;
  localparam logic [7:0] OFS_IMASK = 8'h34;
  localparam logic [7:0] OFS_ITYPE = 8'h38;
  localparam logic [7:0] OFS_IPOL  = 8'h3C;
  localparam logic [7:0] OFS_ISTAT = 8'h40;
  localparam logic [7:0] OFS_DBEN  = 8'h48;
  localparam logic [7:0] OFS_EOI   = 8'h4C;
  localparam logic [7:0] OFS_EXT0  = 8'h50;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_DIR, SEL_EXT,
    SEL_IEN, SEL_IMASK, SEL_ITYPE, SEL_IPOL,
    SEL_ISTAT, SEL_DBEN, SEL_EOI
  } reg_sel_e;

  function automatic logic [7:0] data_ofs(input int unsigned p);
    return 8'(p * 12);
  endfunction

  function automatic logic [7:0] dir_ofs(input int unsigned p);
    return 8'(p * 12 + 4);
  endfunction

  function automatic logic [7:0] ext_ofs(input int unsigned p);
    return OFS_EXT0 + 8'(p * 4);
  endfunction

  // Edges that match each pin's type and polarity
  function automatic logic [31:0] edge_hits(input logic [31:0] cur, prev, typ, pol);
    return typ & ((pol & cur & ~prev) | (~pol & ~cur & prev));
  endfunction

  // Level-sensitive pins currently at their active level
  function automatic logic [31:0] level_active(input logic [31:0] cur, typ, pol);
    return ~typ & ~(cur ^ pol);
  endfunction

  // Edge latch update: clear by write-one, new edge wins, only while armed
  function automatic logic [31:0] next_pending(input logic [31:0] pend, clr, hits, typ, en);
    return typ & en & ((pend & ~clr) | hits);
  endfunction

  function automatic logic [31:0] visible(input logic [31:0] raw, en, mask);
    return raw & en & ~mask;
  endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_data) data_q <= wdata;
      if (wr_dir)  dir_q  <= wdata;
    end
  end

endmodule

// File: rtl/gpio_sync_filter.sv
module gpio_sync_filter #(
  parameter int unsigned W         = 8,
  parameter int unsigned DB_CYCLES = 4,
  parameter bit          HAS_DB    = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  input  logic [W-1:0] db_en,
  input  logic         db_tick,
  output logic [W-1:0] filt_out
);

  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= raw_in;
      s2_q <= s1_q;
    end
  end

  if (HAS_DB) begin : g_db
    localparam int unsigned CW = (DB_CYCLES > 1) ? $clog2(DB_CYCLES) : 1;
    for (genvar i = 0; i < W; i++) begin : g_pin
      logic [CW-1:0] cnt_q;
      logic          val_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
          val_q <= 1'b0;
        end else if (!db_en[i]) begin
          val_q <= s2_q[i];
          cnt_q <= '0;
        end else if (s2_q[i] == val_q) begin
          cnt_q <= '0;
        end else if (db_tick) begin
          if (cnt_q == CW'(DB_CYCLES - 1)) begin
            val_q <= s2_q[i];
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
      assign filt_out[i] = db_en[i] ? val_q : s2_q[i];
    end
  end else begin : g_pass
    logic unused_db;
    assign unused_db = &{1'b0, db_en, db_tick};
    assign filt_out  = s2_q;
  end

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  input  logic [W-1:0] en,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] typ,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  output logic [W-1:0] hit,
  output logic [W-1:0] pend,
  output logic [W-1:0] status,
  output logic         irq
);

  logic [W-1:0] prev_q;
  logic [W-1:0] level;
  logic [W-1:0] pend_d;

  assign hit    = W'(edge_hits(32'(pin), 32'(prev_q), 32'(typ), 32'(pol)));
  assign level  = W'(level_active(32'(pin), 32'(typ), 32'(pol)));
  assign pend_d = W'(next_pending(32'(pend), 32'(clr), 32'(hit), 32'(typ), 32'(en)));
  assign status = W'(visible(32'(pend | level), 32'(en), 32'(mask)));
  assign irq    = |status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend   <= '0;
    end else begin
      prev_q <= pin;
      pend   <= pend_d;
    end
  end

endmodule

// File: rtl/gpio_apb_ctrl.sv
module gpio_apb_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NUM_PORTS  = 4,
  parameter int unsigned PORT_WIDTH = 8,
  parameter int unsigned DB_CYCLES  = 4,
  parameter int unsigned ADDR_W     = 7
) (
  input  logic                             pclk,
  input  logic                             presetn,
  input  logic                             psel,
  input  logic                             penable,
  input  logic                             pwrite,
  input  logic [ADDR_W-1:0]                paddr,
  input  logic [31:0]                      pwdata,
  output logic [31:0]                      prdata,
  input  logic [NUM_PORTS*PORT_WIDTH-1:0]  ext_in,
  output logic [NUM_PORTS*PORT_WIDTH-1:0]  pad_out,
  output logic [NUM_PORTS*PORT_WIDTH-1:0]  pad_oe,
  input  logic                             db_tick,
  output logic                             irq
);

  localparam int unsigned W = PORT_WIDTH;

  logic       wr_acc;
  logic [7:0] waddr;
  reg_sel_e   sel;
  logic [1:0] sel_port;

  logic [W-1:0] data_q   [MAX_PORTS];
  logic [W-1:0] dir_q    [MAX_PORTS];
  logic [W-1:0] ext_view [MAX_PORTS];

  logic [W-1:0] ien_q, imask_q, itype_q, ipol_q, idb_q;
  logic [W-1:0] eoi_clr, pin_a, a_hit, a_pend, a_status;
  logic [31:0]  rd_word;

  assign wr_acc = psel & penable & pwrite;
  assign waddr  = 8'({paddr[ADDR_W-1:2], 2'b00});

  logic unused_addr;
  assign unused_addr = &{1'b0, paddr[1:0]};
  if (W < 32) begin : g_unused_wdata
    logic unused_wdata;
    assign unused_wdata = &{1'b0, pwdata[31:W]};
  end

  // Address decode
  always_comb begin
    sel      = SEL_NONE;
    sel_port = '0;
    case (waddr)
      OFS_IEN:   sel = SEL_IEN;
      OFS_IMASK: sel = SEL_IMASK;
      OFS_ITYPE: sel = SEL_ITYPE;
      OFS_IPOL:  sel = SEL_IPOL;
      OFS_ISTAT: sel = SEL_ISTAT;
      OFS_DBEN:  sel = SEL_DBEN;
      OFS_EOI:   sel = SEL_EOI;
      default:   ;
    endcase
    for (int unsigned p = 0; p < NUM_PORTS; p++) begin
      if (waddr == data_ofs(p)) begin sel = SEL_DATA; sel_port = 2'(p); end
      if (waddr == dir_ofs(p))  begin sel = SEL_DIR;  sel_port = 2'(p); end
      if (waddr == ext_ofs(p))  begin sel = SEL_EXT;  sel_port = 2'(p); end
    end
  end

  // Port 0 interrupt configuration
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ien_q   <= '0;
      imask_q <= '0;
      itype_q <= '0;
      ipol_q  <= '0;
      idb_q   <= '0;
    end else if (wr_acc) begin
      case (sel)
        SEL_IEN:   ien_q   <= pwdata[W-1:0];
        SEL_IMASK: imask_q <= pwdata[W-1:0];
        SEL_ITYPE: itype_q <= pwdata[W-1:0];
        SEL_IPOL:  ipol_q  <= pwdata[W-1:0];
        SEL_DBEN:  idb_q   <= pwdata[W-1:0];
        default:   ;
      endcase
    end
  end

  assign eoi_clr = (wr_acc && sel == SEL_EOI) ? pwdata[W-1:0] : '0;

  // Per-port registers and input paths
  for (genvar p = 0; p < MAX_PORTS; p++) begin : g_port
    if (p < NUM_PORTS) begin : g_on
      logic wr_d, wr_r;
      assign wr_d = wr_acc && sel == SEL_DATA && sel_port == 2'(p);
      assign wr_r = wr_acc && sel == SEL_DIR  && sel_port == 2'(p);

      gpio_port_regs #(.W(W)) u_regs (
        .clk    (pclk),
        .rst_n  (presetn),
        .wr_data(wr_d),
        .wr_dir (wr_r),
        .wdata  (pwdata[W-1:0]),
        .data_q (data_q[p]),
        .dir_q  (dir_q[p])
      );

      gpio_sync_filter #(.W(W), .DB_CYCLES(DB_CYCLES), .HAS_DB(p == 0)) u_in (
        .clk     (pclk),
        .rst_n   (presetn),
        .raw_in  (ext_in[p*W +: W]),
        .db_en   ((p == 0) ? idb_q : '0),
        .db_tick (db_tick),
        .filt_out(ext_view[p])
      );

      assign pad_out[p*W +: W] = data_q[p];
      assign pad_oe[p*W +: W]  = dir_q[p];
    end else begin : g_off
      assign data_q[p]   = '0;
      assign dir_q[p]    = '0;
      assign ext_view[p] = '0;
    end
  end

  assign pin_a = ext_view[0];

  gpio_edge_irq #(.W(W)) u_irq (
    .clk   (pclk),
    .rst_n (presetn),
    .pin   (pin_a),
    .en    (ien_q),
    .mask  (imask_q),
    .typ   (itype_q),
    .pol   (ipol_q),
    .clr   (eoi_clr),
    .hit   (a_hit),
    .pend  (a_pend),
    .status(a_status),
    .irq   (irq)
  );

  // Read path
  always_comb begin
    rd_word = '0;
    case (sel)
      SEL_DATA:  rd_word[W-1:0] = data_q[sel_port];
      SEL_DIR:   rd_word[W-1:0] = dir_q[sel_port];
      SEL_EXT:   rd_word[W-1:0] = ext_view[sel_port];
      SEL_IEN:   rd_word[W-1:0] = ien_q;
      SEL_IMASK: rd_word[W-1:0] = imask_q;
      SEL_ITYPE: rd_word[W-1:0] = itype_q;
      SEL_IPOL:  rd_word[W-1:0] = ipol_q;
      SEL_ISTAT: rd_word[W-1:0] = a_status;
      SEL_DBEN:  rd_word[W-1:0] = idb_q;
      default:   ;
    endcase
    prdata = (psel && !pwrite) ? rd_word : '0;
  end

endmodule

// File: rtl/gpio_apb_ctrl_chk.sv
module gpio_apb_ctrl_chk #(
  parameter int unsigned W    = 8,
  parameter int unsigned PINS = 32
) (
  input logic            pclk,
  input logic            presetn,
  input logic            wr_acc,
  input logic            db_tick,
  input logic            irq,
  input logic [PINS-1:0] pad_oe,
  input logic [W-1:0]    pin_a,
  input logic [W-1:0]    a_hit,
  input logic [W-1:0]    a_pend,
  input logic [W-1:0]    eoi_clr,
  input logic [W-1:0]    itype_q,
  input logic [W-1:0]    ien_q,
  input logic [W-1:0]    imask_q,
  input logic [W-1:0]    idb_q
);

  // R2: drive enables move only on a bus write
  a_r2_oe_holds: assert property (@(posedge pclk) disable iff (!presetn)
    !wr_acc |=> $stable(pad_oe));

  // R5: an armed latch without a clear bit survives the edge
  a_r5_pend_kept: assert property (@(posedge pclk) disable iff (!presetn)
    1'b1 |=> ((($past(a_pend) & ~$past(eoi_clr) & $past(itype_q) & $past(ien_q)) & ~a_pend) == '0));

  // R6: a detected edge on an armed pin always sets the latch, clear or not
  a_r6_hit_sets: assert property (@(posedge pclk) disable iff (!presetn)
    1'b1 |=> ((($past(a_hit) & $past(itype_q) & $past(ien_q)) & ~a_pend) == '0));

  // R4: level pins never hold a latched event
  a_r4_level_no_latch: assert property (@(posedge pclk) disable iff (!presetn)
    1'b1 |=> ((a_pend & ~$past(itype_q)) == '0));

  // R7: a full mask silences the interrupt line
  a_r7_full_mask: assert property (@(posedge pclk) disable iff (!presetn)
    (&imask_q) |-> !irq);

  // R9: a debounced pin changes only after a tick sample
  a_r9_db_hold: assert property (@(posedge pclk) disable iff (!presetn)
    1'b1 |=> ((($past(idb_q) & idb_q & {W{~$past(db_tick)}}) & ($past(pin_a) ^ pin_a)) == '0));

endmodule

bind gpio_apb_ctrl gpio_apb_ctrl_chk #(.W(PORT_WIDTH), .PINS(NUM_PORTS*PORT_WIDTH)) u_chk (
  .pclk   (pclk),
  .presetn(presetn),
  .wr_acc (wr_acc),
  .db_tick(db_tick),
  .irq    (irq),
  .pad_oe (pad_oe),
  .pin_a  (pin_a),
  .a_hit  (a_hit),
  .a_pend (a_pend),
  .eoi_clr(eoi_clr),
  .itype_q(itype_q),
  .ien_q  (ien_q),
  .imask_q(imask_q),
  .idb_q  (idb_q)
);

// File: tb/tb_gpio_apb_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_apb_ctrl;

  localparam int NP = 4;
  localparam int PW = 8;
  localparam int DBN = 4;

  localparam logic [6:0] A_EN = 7'h30, A_MASK = 7'h34, A_TYPE = 7'h38, A_POL = 7'h3C;
  localparam logic [6:0] A_STAT = 7'h40, A_DB = 7'h48, A_CLR = 7'h4C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [6:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [NP*PW-1:0] ext_in = '0;
  logic [NP*PW-1:0] pad_out, pad_oe;
  logic        db_tick = 1'b1;
  logic        irq;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_apb_ctrl #(.NUM_PORTS(NP), .PORT_WIDTH(PW), .DB_CYCLES(DBN), .ADDR_W(7)) dut (
    .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .ext_in(ext_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .db_tick(db_tick), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the falling edge following the write edge
  task automatic apb_wr(input logic [6:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(posedge clk); @(negedge clk);
    penable = 1'b1;
    @(posedge clk); @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [6:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    #1 d = prdata;
    psel = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    apb_rd(7'h00, v); chk("R1 data0", v, 0);
    apb_rd(7'h04, v); chk("R1 dir0", v, 0);
    apb_rd(A_EN, v);  chk("R1 enable", v, 0);
    apb_rd(A_STAT, v); chk("R1 status", v, 0);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 pad_out", pad_out, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_port_regs();
    logic [31:0] v;
    for (int p = 0; p < NP; p++) begin
      apb_wr(7'(12*p), 32'hFFFF_FF00 | 32'(8'hA5 ^ p));
      apb_wr(7'(12*p+4), 32'(8'h0F << p));
    end
    for (int p = 0; p < NP; p++) begin
      chk("R2 pad_out", 32'(pad_out[p*PW +: PW]), 32'(8'hA5 ^ p));
      chk("R2 pad_oe", 32'(pad_oe[p*PW +: PW]), 32'(8'(8'h0F << p)));
      apb_rd(7'(12*p), v);
      chk("R11 data upper bits", v, 32'(8'hA5 ^ p));
      apb_rd(7'(12*p+4), v);
      chk("R2 dir readback", v, 32'(8'(8'h0F << p)));
    end
  endtask

  task automatic t_ext_latency();
    logic [31:0] v;
    ext_in[23:16] = 8'h6C;
    psel = 1'b1; pwrite = 1'b0; paddr = 7'h58;
    #1 chk("R3 before edge", prdata, 0);
    @(posedge clk); #1 chk("R3 after one edge", prdata, 0);
    @(posedge clk); #1 chk("R3 after two edges", prdata, 32'h6C);
    @(negedge clk); psel = 1'b0;
    ext_in[15:8] = 8'h93;
    wait_cyc(3);
    apb_rd(7'h54, v); chk("R3 port1 view", v, 32'h93);
    ext_in[31:8] = '0;
    wait_cyc(3);
  endtask

  task automatic t_level();
    logic [31:0] v;
    apb_wr(A_TYPE, 32'h00);
    apb_wr(A_POL, 32'h04);
    apb_wr(A_EN, 32'h04);
    chk("R4 idle low", {31'd0, irq}, 0);
    ext_in[2] = 1'b1; wait_cyc(3);
    apb_rd(A_STAT, v); chk("R4 high active", v, 32'h04);
    chk("R8 irq from status", {31'd0, irq}, 1);
    ext_in[2] = 1'b0; wait_cyc(3);
    apb_rd(A_STAT, v); chk("R4 drops without clear", v, 0);
    chk("R4 irq drops", {31'd0, irq}, 0);
    apb_wr(A_POL, 32'h00);
    apb_rd(A_STAT, v); chk("R4 low active", v, 32'h04);
    apb_wr(A_EN, 32'h00);
    chk("R8 disabled level", {31'd0, irq}, 0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    apb_wr(A_TYPE, 32'h18);
    apb_wr(A_POL, 32'h08);
    apb_wr(A_EN, 32'h18);
    ext_in[3] = 1'b1;
    @(posedge clk); @(posedge clk); #1 chk("R5 not yet at edge 2", {31'd0, irq}, 0);
    @(posedge clk); #1 chk("R5 visible at edge 3", {31'd0, irq}, 1);
    @(negedge clk);
    ext_in[3] = 1'b0; wait_cyc(3);
    apb_rd(A_STAT, v); chk("R5 latched after fall", v, 32'h08);
    apb_wr(A_CLR, 32'hF7);
    apb_rd(A_STAT, v); chk("R5 zero bits keep latch", v, 32'h08);
    ext_in[4] = 1'b1; wait_cyc(3);
    apb_rd(A_STAT, v); chk("R5 rise ignored on falling pin", v, 32'h08);
    ext_in[4] = 1'b0; wait_cyc(3);
    apb_rd(A_STAT, v); chk("R5 falling edge latched", v, 32'h18);
    apb_wr(A_CLR, 32'h08);
    apb_rd(A_STAT, v); chk("R5 clear one pin", v, 32'h10);
    apb_wr(A_CLR, 32'h10);
    apb_rd(A_STAT, v); chk("R5 clear second pin", v, 0);
    chk("R8 irq low when none", {31'd0, irq}, 0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    ext_in[3] = 1'b1; wait_cyc(3);
    ext_in[3] = 1'b0; wait_cyc(3);
    apb_rd(A_STAT, v); chk("R6 setup pending", v, 32'h08);
    ext_in[3] = 1'b1;
    @(posedge clk); @(negedge clk);
    apb_wr(A_CLR, 32'h08);
    apb_rd(A_STAT, v); chk("R6 new edge wins over clear", v, 32'h08);
    apb_wr(A_CLR, 32'h08);
    apb_rd(A_STAT, v); chk("R6 later clear works", v, 0);
  endtask

  task automatic t_mask_enable();
    logic [31:0] v;
    ext_in[3] = 1'b0; wait_cyc(3);
    ext_in[3] = 1'b1; wait_cyc(3);
    apb_wr(A_MASK, 32'h08);
    apb_rd(A_STAT, v); chk("R7 masked status", v, 0);
    chk("R7 masked irq", {31'd0, irq}, 0);
    apb_wr(A_MASK, 32'h00);
    apb_rd(A_STAT, v); chk("R7 latch kept under mask", v, 32'h08);
    apb_wr(A_TYPE, 32'h38);
    apb_wr(A_POL, 32'h28);
    ext_in[5] = 1'b1; wait_cyc(3);
    apb_wr(A_EN, 32'h38);
    apb_rd(A_STAT, v); chk("R7 no latch while disabled", v, 32'h08);
    apb_wr(A_MASK, 32'hFF);
    chk("R7 all-ones mask", {31'd0, irq}, 0);
    apb_wr(A_MASK, 32'h00);
    apb_wr(A_CLR, 32'hFF);
    apb_rd(A_STAT, v); chk("R5 clear all", v, 0);
    ext_in[5] = 1'b0; ext_in[3] = 1'b0;
    apb_wr(A_EN, 32'h00);
    apb_wr(A_TYPE, 32'h00);
    wait_cyc(3);
  endtask

  task automatic t_debounce();
    logic [31:0] v;
    db_tick = 1'b1;
    apb_wr(A_DB, 32'h40);
    apb_wr(A_POL, 32'h40);
    apb_wr(A_EN, 32'h40);
    ext_in[6] = 1'b1; @(posedge clk); @(posedge clk); @(negedge clk);
    ext_in[6] = 1'b0; wait_cyc(8);
    apb_rd(7'h50, v); chk("R9 glitch filtered", v, 0);
    chk("R9 glitch no irq", {31'd0, irq}, 0);
    ext_in[6] = 1'b1; wait_cyc(10);
    apb_rd(7'h50, v); chk("R9 stable input accepted", v, 32'h40);
    chk("R9 irq after accept", {31'd0, irq}, 1);
    db_tick = 1'b0;
    ext_in[6] = 1'b0; wait_cyc(10);
    apb_rd(7'h50, v); chk("R9 no ticks no change", v, 32'h40);
    db_tick = 1'b1; wait_cyc(10);
    apb_rd(7'h50, v); chk("R9 accepted with ticks", v, 0);
    ext_in[7] = 1'b1; wait_cyc(2);
    apb_rd(7'h50, v); chk("R9 undebounced pin direct", v, 32'h80);
    ext_in[7] = 1'b0;
    apb_wr(A_EN, 32'h00);
    apb_wr(A_DB, 32'h00);
    wait_cyc(3);
  endtask

  task automatic t_other_ports();
    logic [31:0] v;
    apb_wr(A_TYPE, 32'hFF);
    apb_wr(A_POL, 32'hFF);
    apb_wr(A_EN, 32'hFF);
    ext_in[31:8] = 24'hFFFFFF; wait_cyc(4);
    ext_in[31:8] = 24'h000000; wait_cyc(4);
    apb_rd(A_STAT, v); chk("R10 other ports no status", v, 0);
    chk("R10 other ports no irq", {31'd0, irq}, 0);
    apb_wr(7'h44, 32'hFFFF_FFFF);
    apb_rd(7'h44, v); chk("R10 unmapped reads zero", v, 0);
    apb_wr(7'h08, 32'hFFFF_FFFF);
    apb_rd(7'h08, v); chk("R10 gap reads zero", v, 0);
    apb_rd(7'h00, v); chk("R10 neighbour untouched", v, 32'hA5);
    apb_rd(7'h04, v); chk("R10 neighbour dir untouched", v, 32'h0F);
    apb_wr(A_EN, 32'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_port_regs();
    t_ext_latency();
    t_level();
    t_edge();
    t_collision();
    t_mask_enable();
    t_debounce();
    t_other_ports();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule